// File: doc/BRIEF.md
# Trigger-Restart Capture Timer

An 8-bit up-counting timer with a capture register and two compare channels. The counter advances either on every system clock or on each rising edge of a count pin. What restarts it depends on the mode. It can run freely. It can be restarted by a selected edge on an external trigger pin. It can also be restarted by each toggle of a companion timer's output flip-flop. A restart stores the count reached into the capture register, clears the counter and leaves it running.

When the count advances onto a compare value, a toggle flip-flop inverts. The output pin shows either this flip-flop or, in the two pass-through modes, the companion timer's output. Either compare channel can be limited to one toggle per arming, and every restart arms it again.

In the internal-trigger mode, with the count pin as the clock source, the block counts events inside a time gate. Each capture then holds the number of events seen since the previous toggle of the companion.

Top module: `trc_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `count`, `cap_val`, `cap_valid` and the toggle flip-flop all become 0, and both compare channels are armed.
- R2: With `run` high, counting modes step `count` by one per tick, wrapping from 255 to 0. A tick is every clock when `clk_sel`=0, or each rising edge of `cnt_pin` when `clk_sel`=1. Mode values 0, 6 and 7 hold `count` at 0.
- R3: Modes 2 and 5 (external trigger) keep `count` at 0 after `run` rises, until the first selected trigger edge. That edge only starts counting.
- R4: In modes 2 and 5, each selected edge after the first copies `count` into `cap_val` and clears `count`. The counter keeps running. The trigger pin passes through two synchronising flops, so a pin change acts on the third clock edge after it.
- R5: `edge_sel` picks the active trigger edge: 00 rising, 01 falling, 1x both. An edge of the other polarity is ignored.
- R6: In mode 3 (internal trigger), any change of `comp_tog` at a clock edge copies `count` into `cap_val` and clears `count`.
- R7: When a tick moves `count` onto `cmp_a` or `cmp_b`, the toggle flip-flop inverts. If both channels match on the same tick, it is left unchanged.
- R8: A channel whose single-action enable is set toggles only on its first match after arming. It is re-armed by every restart and while `run` is low.
- R9: In modes 4 and 5, `out_pin` follows `comp_out`. In all other modes it shows the toggle flip-flop.
- R10: `cap_valid` goes to 1 on every capture. It returns to 0 on a clock edge with `cap_ack` high and no capture, and otherwise holds its value.
- R11: `run` low clears `count` to 0 and puts the external-trigger modes back into waiting for a first edge.
- R12: Mode encoding: 1 free-running, 2 external trigger, 3 internal trigger, 4 free-running with pass-through output, 5 external trigger with pass-through output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables counting; low clears and disarms the start |
| mode | input | 3 | Operating mode, encoded as in R12 |
| edge_sel | input | 2 | Active trigger edge: 00 rising, 01 falling, 1x both |
| clk_sel | input | 1 | Tick source: 0 system clock, 1 rising edges of `cnt_pin` |
| cnt_pin | input | 1 | Asynchronous external count input |
| trig_pin | input | 1 | Asynchronous external trigger input |
| comp_tog | input | 1 | Companion timer's toggle flip-flop level (synchronous) |
| comp_out | input | 1 | Companion timer's output, used in pass-through modes |
| cmp_a | input | 8 | Compare value, channel A |
| cmp_b | input | 8 | Compare value, channel B |
| single_a | input | 1 | Single-action enable, channel A |
| single_b | input | 1 | Single-action enable, channel B |
| cap_ack | input | 1 | Acknowledge that clears `cap_valid` |
| cap_val | output | 8 | Capture register |
| cap_valid | output | 1 | A capture has occurred since the last acknowledge |
| count | output | 8 | Current counter value |
| out_pin | output | 1 | Toggle flip-flop or companion output |

## Verification
The assertions check local invariants on every cycle. A restart leaves the counter at zero with the valid flag set. A tick moves the count up by exactly one. A waiting external-trigger counter never moves. A single-action channel that fires is disarmed. The valid flag holds until it is acknowledged. A low run bit clears the count. Only the bench scenarios can show the end-to-end results: the three-edge trigger latency, the captured values, that edges of the wrong polarity are ignored, the number of output toggles over long windows with wrap-around and simultaneous matches, re-arming after a restart, the gated event count, and the pass-through multiplexing.

// File: rtl/trc_pkg.sv
// Shared types and mode decoding for the trigger-restart capture timer.
// Assumes the 3-bit mode encoding of the brief; unused codes decode to idle.
package trc_pkg;

    typedef enum logic [1:0] {
        KIND_IDLE = 2'd0,
        KIND_FREE = 2'd1,
        KIND_EXT  = 2'd2,
        KIND_INT  = 2'd3
    } kind_t;

    // Maps a mode code to the restart source it implies.
    function automatic kind_t decode_kind(input logic [2:0] m);
        case (m)
            3'd1, 3'd4: decode_kind = KIND_FREE;
            3'd2, 3'd5: decode_kind = KIND_EXT;
            3'd3:       decode_kind = KIND_INT;
            default:    decode_kind = KIND_IDLE;
        endcase
    endfunction

    // True for the modes whose pin shows the companion output.
    function automatic logic is_passthru(input logic [2:0] m);
        is_passthru = (m == 3'd4) || (m == 3'd5);
    endfunction

endpackage

// File: rtl/trc_sync_edge.sv
// Synchronises an asynchronous pin through STAGES flops and reports the
// selected edge as a one-cycle pulse. sel: 00 rising, 01 falling, 1x both.
// Assumes STAGES >= 2.
module trc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic [1:0] sel,
    output logic       evt
);
    logic [STAGES-1:0] chain;
    logic              last;
    logic              rise;
    logic              fall;

    // Shift the pin through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    // Edge detection on the synchronised level and polarity selection.
    always_comb begin
        rise = chain[STAGES-1] & ~last;
        fall = ~chain[STAGES-1] & last;
        case (sel)
            2'b00:   evt = rise;
            2'b01:   evt = fall;
            default: evt = rise | fall;
        endcase
    end

endmodule

// File: rtl/trc_count_core.sv
// Counter, start/wait state and capture register. A restart (a trigger after
// the start in external mode, or a companion toggle in internal mode) captures
// the count and clears it. Assumes tick, trig_evt and tog_evt are synchronous.
module trc_count_core
    import trc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  kind_t        kind,
    input  logic         tick,
    input  logic         trig_evt,
    input  logic         tog_evt,
    input  logic         cap_ack,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         step,
    output logic         restart,
    output logic [W-1:0] cap,
    output logic         cap_valid
);
    logic started;
    logic start_now;
    logic waiting;
    logic active;

    // Decide this cycle's action: start, restart or step.
    always_comb begin
        active    = run && (kind != KIND_IDLE);
        waiting   = (kind == KIND_EXT) && !started;
        start_now = active && waiting && trig_evt;
        restart   = active && (((kind == KIND_EXT) && started && trig_evt)
                               || ((kind == KIND_INT) && tog_evt));
        step      = active && !waiting && !restart && tick;
        cnt_nxt   = cnt + W'(1);
    end

    // Counter and started flag; run low or idle mode clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            started <= 1'b0;
        end else if (!active) begin
            cnt     <= '0;
            started <= 1'b0;
        end else begin
            if (start_now) started <= 1'b1;
            if (restart)   cnt <= '0;
            else if (step) cnt <= cnt_nxt;
        end
    end

    // Capture register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap       <= '0;
            cap_valid <= 1'b0;
        end else if (restart) begin
            cap       <= cnt;
            cap_valid <= 1'b1;
        end else if (cap_ack) begin
            cap_valid <= 1'b0;
        end
    end

    a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0) && cap_valid);

    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt == W'($past(cnt) + W'(1))));

    a_r3_waiting_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (active && waiting) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/trc_cmp_unit.sv
// One compare channel: reports a hit when a counter step lands on the compare
// value. In single-action mode only the first hit after arming counts.
module trc_cmp_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] cmp,
    input  logic         single,
    input  logic         rearm,
    output logic         hit
);
    logic armed;

    // A match counts unless a single-action channel is already spent.
    always_comb begin
        hit = step && (cnt_nxt == cmp) && (!single || armed);
    end

    // Arm on reset or rearm; disarm after a single-action hit.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed <= 1'b1;
        else if (rearm)            armed <= 1'b1;
        else if (hit && single)    armed <= 1'b0;
    end

    a_r8_single_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && single && !rearm) |=> !armed);

endmodule

// File: rtl/trc_timer.sv
// Top of the trigger-restart capture timer: input synchronisers, counter core,
// compare channels, toggle flip-flop and output multiplexer.
// Assumes comp_tog and comp_out are already synchronous to clk.
module trc_timer
    import trc_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [2:0]   mode,
    input  logic [1:0]   edge_sel,
    input  logic         clk_sel,
    input  logic         cnt_pin,
    input  logic         trig_pin,
    input  logic         comp_tog,
    input  logic         comp_out,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         single_a,
    input  logic         single_b,
    input  logic         cap_ack,
    output logic [W-1:0] cap_val,
    output logic         cap_valid,
    output logic [W-1:0] count,
    output logic         out_pin
);
    localparam int NCMP = 2;

    kind_t                    kind;
    logic                     trig_evt;
    logic                     cnt_evt;
    logic                     tick;
    logic                     tog_prev;
    logic                     tog_evt;
    logic [W-1:0]             cnt_nxt;
    logic                     step;
    logic                     restart;
    logic                     rearm;
    logic                     tff;
    logic [NCMP-1:0][W-1:0]   cmp_vec;
    logic [NCMP-1:0]          single_vec;
    logic [NCMP-1:0]          hits;

    // Decode the mode and pick the tick source.
    always_comb begin
        kind       = decode_kind(mode);
        tick       = clk_sel ? cnt_evt : 1'b1;
        tog_evt    = comp_tog ^ tog_prev;
        rearm      = restart || !run;
        cmp_vec    = {cmp_b, cmp_a};
        single_vec = {single_b, single_a};
    end

    trc_sync_edge #(.STAGES(STAGES)) u_trig (
        .clk(clk), .rst_n(rst_n), .din(trig_pin), .sel(edge_sel), .evt(trig_evt)
    );

    trc_sync_edge #(.STAGES(STAGES)) u_cntp (
        .clk(clk), .rst_n(rst_n), .din(cnt_pin), .sel(2'b00), .evt(cnt_evt)
    );

    trc_count_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .kind(kind), .tick(tick),
        .trig_evt(trig_evt), .tog_evt(tog_evt), .cap_ack(cap_ack),
        .cnt(count), .cnt_nxt(cnt_nxt), .step(step), .restart(restart),
        .cap(cap_val), .cap_valid(cap_valid)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        trc_cmp_unit #(.W(W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .step(step), .cnt_nxt(cnt_nxt),
            .cmp(cmp_vec[i]), .single(single_vec[i]), .rearm(rearm),
            .hit(hits[i])
        );
    end

    // Remember the companion toggle level to detect its changes.
    always_ff @(posedge clk) begin
        if (!rst_n) tog_prev <= 1'b0;
        else        tog_prev <= comp_tog;
    end

    // Output toggle flip-flop; simultaneous hits cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) tff <= 1'b0;
        else        tff <= tff ^ (^hits);
    end

    // Output pin multiplexer.
    always_comb begin
        out_pin = is_passthru(mode) ? comp_out : tff;
    end

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0));

    a_r10_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_ack) |=> cap_valid);

endmodule

// File: tb/sim_trc_timer.sv
module sim_trc_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, run, clk_sel, cnt_pin, trig_pin, comp_tog, comp_out;
    logic       single_a, single_b, cap_ack;
    logic [2:0] mode;
    logic [1:0] edge_sel;
    logic [7:0] cmp_a, cmp_b, cap_val, count;
    logic       cap_valid, out_pin;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trc_timer u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .edge_sel(edge_sel),
        .clk_sel(clk_sel), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .comp_tog(comp_tog), .comp_out(comp_out), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .single_a(single_a), .single_b(single_b), .cap_ack(cap_ack),
        .cap_val(cap_val), .cap_valid(cap_valid), .count(count), .out_pin(out_pin)
    );

    typedef struct packed {
        logic [2:0]  md;
        logic [7:0]  ca;
        logic [7:0]  cb;
        logic        sa;
        logic        sb;
        logic [15:0] win;
        logic [7:0]  ecnt;
        logic [7:0]  etog;
    } vec_t;

    // Free-running compare scenarios: expected count = win mod 256, toggles per R7/R8.
    localparam vec_t VECS [8] = '{
        '{3'd1, 8'd5,   8'd200, 1'b0, 1'b0, 16'd20,  8'd20, 8'd1},
        '{3'd1, 8'd5,   8'd10,  1'b0, 1'b0, 16'd20,  8'd20, 8'd2},
        '{3'd1, 8'd5,   8'd250, 1'b0, 1'b0, 16'd300, 8'd44, 8'd3},
        '{3'd1, 8'd5,   8'd250, 1'b1, 1'b1, 16'd300, 8'd44, 8'd2},
        '{3'd1, 8'd7,   8'd7,   1'b0, 1'b0, 16'd20,  8'd20, 8'd0},
        '{3'd4, 8'd5,   8'd10,  1'b0, 1'b0, 16'd20,  8'd20, 8'd0},
        '{3'd1, 8'd0,   8'd100, 1'b0, 1'b0, 16'd300, 8'd44, 8'd2},
        '{3'd0, 8'd5,   8'd10,  1'b0, 1'b0, 16'd20,  8'd0,  8'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = 1'b0; mode = 3'd0; edge_sel = 2'b00; clk_sel = 1'b0;
        cnt_pin = 1'b0; trig_pin = 1'b0; comp_tog = 1'b0; comp_out = 1'b0;
        cmp_a = 8'd200; cmp_b = 8'd201; single_a = 1'b0; single_b = 1'b0; cap_ack = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic cnt_pulse();
        cnt_pin = 1'b1; tick(2);
        cnt_pin = 1'b0; tick(2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        int toggles;
        logic prev;

        // R1: reset state
        do_reset();
        check(count == 0 && cap_val == 0 && cap_valid == 0 && out_pin == 0,
              "R1 reset", int'(count) + int'(cap_val) + int'(cap_valid) + int'(out_pin), 0);

        // R2 R7 R8 R9 R12: table of free-running compare scenarios
        for (int i = 0; i < 8; i++) begin
            do_reset();
            mode = VECS[i].md; cmp_a = VECS[i].ca; cmp_b = VECS[i].cb;
            single_a = VECS[i].sa; single_b = VECS[i].sb;
            run = 1'b1;
            toggles = 0;
            prev = out_pin;
            for (int k = 0; k < int'(VECS[i].win); k++) begin
                tick(1);
                if (out_pin != prev) toggles++;
                prev = out_pin;
            end
            check(count == VECS[i].ecnt, "R2 count after window", count, VECS[i].ecnt);
            check(toggles == int'(VECS[i].etog), "R7 R8 R9 toggles", toggles, VECS[i].etog);
        end

        // R3 R4 R5 R10 R11: external trigger, rising edge
        do_reset();
        mode = 3'd2; run = 1'b1;
        tick(5);
        check(count == 0, "R3 waits before first edge", count, 0);
        trig_pin = 1'b1; tick(3);
        check(count == 0, "R3 first edge only starts", count, 0);
        tick(1);
        check(count == 1, "R3 counting after start", count, 1);
        tick(9);
        check(count == 10, "R2 clock ticks", count, 10);
        trig_pin = 1'b0; tick(6);
        check(count == 16 && cap_valid == 0, "R5 falling ignored", count, 16);
        c0 = count;
        trig_pin = 1'b1; tick(3);
        check(cap_val == c0 + 2, "R4 capture value", cap_val, c0 + 2);
        check(count == 0 && cap_valid == 1, "R4 restart clears, R10 valid", count, 0);
        cap_ack = 1'b1; tick(1); cap_ack = 1'b0;
        check(cap_valid == 0, "R10 ack clears", cap_valid, 0);
        edge_sel = 2'b10;
        c0 = count;
        trig_pin = 1'b0; tick(3);
        check(cap_val == c0 + 2, "R5 both edges capture", cap_val, c0 + 2);
        run = 1'b0; tick(2);
        check(count == 0, "R11 run low clears", count, 0);
        run = 1'b1; tick(6);
        check(count == 0, "R11 back to waiting", count, 0);
        trig_pin = 1'b1; tick(4);
        check(count == 1, "R11 restart after new edge", count, 1);

        // R5: falling-only selection
        do_reset();
        mode = 3'd2; edge_sel = 2'b01; run = 1'b1;
        trig_pin = 1'b1; tick(6);
        check(count == 0, "R5 rising ignored in falling mode", count, 0);
        trig_pin = 1'b0; tick(4);
        check(count == 1, "R5 falling starts", count, 1);

        // R8: single action re-armed by restart
        do_reset();
        mode = 3'd2; cmp_a = 8'd3; cmp_b = 8'd100; single_a = 1'b1; single_b = 1'b1;
        run = 1'b1; tick(2);
        trig_pin = 1'b1; tick(4);
        check(count == 1, "R3 start", count, 1);
        tick(39);
        check(out_pin == 1, "R7 first match toggles", out_pin, 1);
        tick(260);
        check(out_pin == 0, "R8 later matches ignored", out_pin, 0);
        trig_pin = 1'b0; tick(3);
        trig_pin = 1'b1; tick(3);
        check(cap_val == 49 && count == 0, "R4 capture 49", cap_val, 49);
        tick(10);
        check(out_pin == 1, "R8 rearmed by restart", out_pin, 1);

        // R9: pass-through in external trigger mode
        mode = 3'd5; comp_out = 1'b1; #1;
        check(out_pin == 1, "R9 pass-through high", out_pin, 1);
        comp_out = 1'b0; #1;
        check(out_pin == 0, "R9 pass-through low", out_pin, 0);

        // R6 R2: internal trigger gated event count
        do_reset();
        mode = 3'd3; clk_sel = 1'b1; run = 1'b1;
        tick(1);
        for (int p = 0; p < 4; p++) cnt_pulse();
        tick(2);
        check(count == 4, "R2 count pin ticks", count, 4);
        comp_tog = 1'b1; tick(1);
        check(cap_val == 4 && count == 0, "R6 capture 4", cap_val, 4);
        for (int p = 0; p < 11; p++) cnt_pulse();
        tick(2);
        comp_tog = 1'b0; tick(1);
        check(cap_val == 11 && count == 0, "R6 capture 11", cap_val, 11);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule